// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block is the part of a small 8-bit bus master that decides whether a maskable interrupt request is taken and then runs the bus cycle that fetches the interrupt vector. The request is looked at only on the clock edge that closes an instruction, which the instruction decoder marks with a one-clock end-of-instruction strobe. The request is taken only if the interrupt-enable flag held inside the block is set and no other master is asking for the bus.

Once a request is taken, the sequencer runs an acknowledge cycle that looks like an opcode fetch. The I/O request strobe is driven in place of the memory request strobe, and the cycle always carries two built-in wait states. These give a ripple-priority chain of peripherals time to settle on which device answers. The wait line can stretch the cycle further. The byte on the data bus is captured at the end of the last wait state and announced with a one-clock accept pulse. Taking a request also clears the enable flag, so no second request is taken until software sets it again.

Top module: `intack_sequencer`

## Requirements
- R1: A synchronous active-low reset, held for at least one clock edge, returns the sequencer to idle. After it, m1N and iorqN are high, vector is 0, accept is 0 and ieFlag is 0.
- R2: A request is taken only at a rising edge where instrEnd is 1 and intN is 0, both together with ieFlag=1 and busReqN=1. If intN is low without instrEnd, or instrEnd is high with intN high, no cycle starts.
- R3: When ieFlag is 0 at the sampling edge, the request is ignored: m1N and iorqN stay high and no accept pulse appears.
- R4: When busReqN is 0 at the sampling edge, the request is ignored in the same way.
- R5: Counting clock periods from the edge that takes the request, with n extra wait states, m1N is low in periods 1 through 4+n and high from period 5+n on. mreqN and rdN stay high at all times.
- R6: iorqN is high in periods 1 and 2 (T1, T2) and low from period 3 through period 4+n, covering both automatic wait states and all extra ones. It is high again in period 5+n.
- R7: With waitN held high, the acknowledge cycle lasts exactly six periods (T1, T2, two automatic waits, T3, T4), and the block is idle again in period 7.
- R8: waitN is first looked at on the edge that ends the second automatic wait state. Each edge at which waitN is 0 adds one more wait state, and the cycle moves on at the first edge where waitN is 1.
- R9: dataIn is captured into vector on the edge that ends the last wait state, so the new value shows in period 5+n. accept is 1 in that period only. vector keeps its value until the next capture, whatever dataIn does.
- R10: A one-clock ieSet pulse sets ieFlag. The edge that takes a request clears ieFlag, and this clear wins over an ieSet given on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rstN | input | 1 | Synchronous reset, active low |
| intN | input | 1 | Maskable interrupt request, active low |
| busReqN | input | 1 | Bus request from another master, active low |
| instrEnd | input | 1 | High during the last clock of an instruction |
| ieSet | input | 1 | Software strobe that sets the interrupt-enable flag |
| waitN | input | 1 | Wait request, active low |
| dataIn | input | VEC_W | Data bus carrying the vector |
| m1N | output | 1 | Opcode-fetch-style cycle marker, active low |
| iorqN | output | 1 | I/O request strobe, active low |
| mreqN | output | 1 | Memory request strobe, held inactive |
| rdN | output | 1 | Read strobe, held inactive |
| vector | output | VEC_W | Captured interrupt vector |
| accept | output | 1 | One-clock pulse when the vector is captured |
| ieFlag | output | 1 | Interrupt-enable flag |

## Verification
The assertions assume that reset is held for at least two clock edges. They also assume that dataIn is stable across the capture edge, and that inputs are defined whenever reset is released. The bench changes every input only on the falling clock edge and always resets through a two-edge task. It holds dataIn at the vector value from the trigger edge until the cycle ends, and it changes dataIn only after capture when it tests that vector holds.

// File: rtl/intack_pkg.sv
package intack_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_TW1  = 3'd3,
    S_TW2  = 3'd4,
    S_TWX  = 3'd5,
    S_T3   = 3'd6,
    S_T4   = 3'd7
  } ackState_t;

  // strobes from control to datapath and pins
  typedef struct packed {
    logic take;   // request accepted on this edge
    logic latch;  // capture data bus on this edge
    logic m1;     // cycle marker active
    logic iorq;   // I/O request active
  } ackStrobe_t;

endpackage

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intN,
  input  logic       busReqN,
  input  logic       instrEnd,
  input  logic       waitN,
  input  logic       ieFlag,
  output ackStrobe_t strb
);

  ackState_t state, stateNext;

  always_comb begin
    strb.take  = (state == S_IDLE) && instrEnd && !intN && ieFlag && busReqN;
    strb.latch = ((state == S_TW2) || (state == S_TWX)) && waitN;
    strb.m1    = (state == S_T1) || (state == S_T2) || (state == S_TW1) ||
                 (state == S_TW2) || (state == S_TWX);
    strb.iorq  = (state == S_TW1) || (state == S_TW2) || (state == S_TWX);
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:        if (strb.take) stateNext = S_T1;
      S_T1:          stateNext = S_T2;
      S_T2:          stateNext = S_TW1;
      S_TW1:         stateNext = S_TW2;
      S_TW2, S_TWX:  stateNext = waitN ? S_T3 : S_TWX;
      S_T3:          stateNext = S_T4;
      S_T4:          stateNext = S_IDLE;
      default:       stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R3: a cleared enable flag keeps the sequencer idle
  p_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !ieFlag) |=> (state == S_IDLE));

  // R4: a pending bus request keeps the sequencer idle
  p_busreq_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !busReqN) |=> (state == S_IDLE));

  // R2: no instruction boundary, no acknowledge cycle
  p_end_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !instrEnd) |=> (state == S_IDLE));

endmodule

// File: rtl/intack_dpath.sv
module intack_dpath
  import intack_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ackStrobe_t       strb,
  input  logic             ieSet,
  input  logic [VEC_W-1:0] dataIn,
  output logic [VEC_W-1:0] vector,
  output logic             accept,
  output logic             ieFlag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vector <= '0;
      accept <= 1'b0;
    end else begin
      accept <= strb.latch;
      if (strb.latch) vector <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          ieFlag <= 1'b0;
    else if (strb.take) ieFlag <= 1'b0;
    else if (ieSet)     ieFlag <= 1'b1;
  end

  // R10: taking a request leaves the flag cleared
  p_ie_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.take |=> !ieFlag);

  // R9: accept lasts one clock
  p_accept_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !accept);

  // R9: vector only moves on a capture edge
  p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latch |=> $stable(vector));

endmodule

// File: rtl/intack_sequencer.sv
module intack_sequencer
  import intack_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             intN,
  input  logic             busReqN,
  input  logic             instrEnd,
  input  logic             ieSet,
  input  logic             waitN,
  input  logic [VEC_W-1:0] dataIn,
  output logic             m1N,
  output logic             iorqN,
  output logic             mreqN,
  output logic             rdN,
  output logic [VEC_W-1:0] vector,
  output logic             accept,
  output logic             ieFlag
);

  ackStrobe_t strb;

  intack_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .intN     (intN),
    .busReqN  (busReqN),
    .instrEnd (instrEnd),
    .waitN    (waitN),
    .ieFlag   (ieFlag),
    .strb     (strb)
  );

  intack_dpath #(.VEC_W(VEC_W)) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .ieSet  (ieSet),
    .dataIn (dataIn),
    .vector (vector),
    .accept (accept),
    .ieFlag (ieFlag)
  );

  assign m1N   = ~strb.m1;
  assign iorqN = ~strb.iorq;
  assign mreqN = 1'b1;
  assign rdN   = 1'b1;

  // R7: once asserted, I/O request covers both automatic waits
  p_two_waits_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(iorqN) |=> !iorqN);

  // R9: the cycle marker ends exactly when the vector is announced
  p_marker_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(m1N) |-> accept);

endmodule

// File: tb/intack_sequencer_test.sv
module intack_sequencer_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       intN = 1'b1;
  logic       busReqN = 1'b1;
  logic       instrEnd = 1'b0;
  logic       ieSet = 1'b0;
  logic       waitN = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic       m1N, iorqN, mreqN, rdN, accept, ieFlag;
  logic [7:0] vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  intack_sequencer #(.VEC_W(8)) uut (
    .clk(clk), .rstN(rstN), .intN(intN), .busReqN(busReqN),
    .instrEnd(instrEnd), .ieSet(ieSet), .waitN(waitN), .dataIn(dataIn),
    .m1N(m1N), .iorqN(iorqN), .mreqN(mreqN), .rdN(rdN),
    .vector(vector), .accept(accept), .ieFlag(ieFlag)
  );

  typedef struct packed {
    logic       ie;
    logic       endStb;
    logic       req;      // intN level
    logic       breq;     // busReqN level
    logic [2:0] waits;
    logic [7:0] data;
    logic       taken;
  } vecT;

  localparam vecT TABLE [7] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, 3'd0, 8'hA5, 1'b1},  // R7 plain cycle
    '{1'b1, 1'b1, 1'b0, 1'b1, 3'd2, 8'h3C, 1'b1},  // R8 two extra waits
    '{1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 8'hFF, 1'b0},  // R3 masked
    '{1'b1, 1'b1, 1'b0, 1'b0, 3'd0, 8'h11, 1'b0},  // R4 bus requested
    '{1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 8'h22, 1'b0},  // R2 no boundary
    '{1'b1, 1'b1, 1'b1, 1'b1, 3'd0, 8'h33, 1'b0},  // R2 no request
    '{1'b1, 1'b1, 1'b0, 1'b1, 3'd1, 8'h00, 1'b1}   // R8 one extra wait
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic pulseIe();
    ieSet = 1'b1;
    @(negedge clk);
    ieSet = 1'b0;
  endtask

  // trigger at the current falling edge and follow the cycle period by period
  task automatic ackSeq(input logic [7:0] data, input int n, input logic [7:0] prevVec);
    instrEnd = 1'b1; intN = 1'b0; busReqN = 1'b1; dataIn = data;
    @(negedge clk);
    instrEnd = 1'b0; intN = 1'b1;
    chk("R10 flag cleared on take", ieFlag, 0);
    for (int c = 1; c <= 7 + n; c++) begin
      chk("R5 m1N", m1N, (c <= 4 + n) ? 0 : 1);
      chk("R6 iorqN", iorqN, (c >= 3 && c <= 4 + n) ? 0 : 1);
      chk("R5 mreqN", mreqN, 1);
      chk("R5 rdN", rdN, 1);
      chk("R9 accept", accept, (c == 5 + n) ? 1 : 0);
      chk("R9 vector", vector, (c >= 5 + n) ? data : prevVec);
      waitN = !(c >= 4 && c < 4 + n);  // R8 hold extra waits
      @(negedge clk);
    end
    waitN = 1'b1;
    chk("R7 idle after cycle", m1N, 1);
  endtask

  task automatic runEntry(input vecT v);
    doReset();
    if (v.ie) pulseIe();
    chk("R10 flag set", ieFlag, v.ie);
    if (v.taken) begin
      ackSeq(v.data, int'(v.waits), 8'h00);
    end else begin
      instrEnd = v.endStb; intN = v.req; busReqN = v.breq; dataIn = v.data;
      @(negedge clk);
      instrEnd = 1'b0; intN = 1'b1; busReqN = 1'b1;
      for (int c = 1; c <= 8; c++) begin
        chk("R2 R3 R4 m1N stays high", m1N, 1);
        chk("R2 R3 R4 iorqN stays high", iorqN, 1);
        chk("R2 R3 R4 no accept", accept, 0);
        @(negedge clk);
      end
      chk("R3 R4 flag unchanged", ieFlag, v.ie);
      chk("R2 vector untouched", vector, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();
    // R1 reset state
    chk("R1 m1N", m1N, 1);
    chk("R1 iorqN", iorqN, 1);
    chk("R1 vector", vector, 0);
    chk("R1 accept", accept, 0);
    chk("R1 ieFlag", ieFlag, 0);

    foreach (TABLE[i]) runEntry(TABLE[i]);

    // R9 vector holds while the bus changes; second cycle needs a new ieSet
    doReset();
    pulseIe();
    ackSeq(8'hC3, 0, 8'h00);
    dataIn = 8'h99;
    repeat (3) @(negedge clk);
    chk("R9 vector holds", vector, 8'hC3);
    chk("R10 flag stays clear", ieFlag, 0);
    instrEnd = 1'b1; intN = 1'b0;
    @(negedge clk);
    instrEnd = 1'b0; intN = 1'b1;
    chk("R10 no nested take", m1N, 1);
    pulseIe();
    ackSeq(8'h47, 3, 8'hC3);

    // R10 take wins over simultaneous ieSet
    pulseIe();
    ieSet = 1'b1; instrEnd = 1'b1; intN = 1'b0; dataIn = 8'h5A;
    @(negedge clk);
    ieSet = 1'b0; instrEnd = 1'b0; intN = 1'b1;
    chk("R10 take beats set", ieFlag, 0);
    chk("R2 cycle started", m1N, 0);
    // R1 reset in the middle of the cycle
    @(negedge clk);
    @(negedge clk);
    chk("R6 iorqN in wait", iorqN, 0);
    doReset();
    chk("R1 m1N after mid reset", m1N, 1);
    chk("R1 iorqN after mid reset", iorqN, 1);
    chk("R1 vector after mid reset", vector, 0);
    chk("R1 accept after mid reset", accept, 0);
    chk("R1 ieFlag after mid reset", ieFlag, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule